// File: doc/BRIEF.md
# Sector Buffer Command Sequencer

This block sits behind a register-style host port of a disk drive controller and runs the commands that work on the 512-byte sector buffer alone. There are four: fill the buffer for the host to read, accept a buffer's worth of data from the host, publish drive identification parameters, and run a self-test. Each command has its own sequence of the busy flag, the data-request flag and the interrupt line. The block counts 16-bit data-port transfers and ends a transfer phase after the whole buffer has moved.

Self-test routines are not modelled here. Three local result inputs and two inputs for the second (slave) drive take their place. From these the block composes a one-byte diagnostic code. The identify image is generated inside the block from geometry parameters.

The host sees eight register addresses. Address 0 is the 16-bit data port. Address 1 reads the error code. Address 7 reads status and takes command writes. Addresses 2 to 6 hold nothing.

Top module: `sb_cmd_seq`

## Requirements
- R1: After reset, status (address 7 read) is 0x40, the error code (address 1 read) is 0x00 and `irq` is low. Status layout: bit 7 busy, bit 6 ready (the inverse of busy), bit 3 data request, bit 0 error. All other status bits are zero.
- R2: Command 0xE4 (read buffer) holds busy for exactly one cycle. It then clears busy, sets data request and raises `irq` in the same cycle. Host reads then return buffer words starting at word 0.
- R3: Command 0xE8 (write buffer) sets data request in the cycle after the command write. Busy and `irq` stay low. Host writes to the data port store words starting at word 0.
- R4: Command 0xEC (identify) holds busy for WORDS cycles while it copies the identify image into the buffer. It then sets data request and raises `irq`. In the image, word 1 holds the cylinders (977 by default), word 3 the heads (10) and word 6 the sectors per track (17). Every other word is 0.
- R5: Command 0x90 (diagnostic) holds busy for DIAG_CYCLES cycles, then clears busy and raises `irq` without data request. The error code's low seven bits are 0x02 if the controller fails, else 0x03 if the buffer fails, else 0x05 if the processor fails, else 0x01. The status error bit is cleared.
- R6: After a diagnostic, error-code bit 7 is 1 only if the slave is present and failed. Otherwise it is 0.
- R7: Data request clears after exactly WORDS data-port transfers in the command's direction. No interrupt is raised at that point. An access in the other direction is not counted.
- R8: Data-port reads and writes while data request is low change neither the buffer nor the word position. Reads return 0.
- R9: A status read clears a pending `irq`. If an interrupt is raised in the same cycle as the clearing read, `irq` stays high.
- R10: Any other command code sets the error code to 0x04 and the status error bit, and raises `irq`. Busy and data request stay low.
- R11: A command write while busy or data request is high is ignored. Writes to addresses 1 to 6 are ignored.
- R12: Accepting 0xE4, 0xE8, 0xEC or 0x90 clears the status error bit and the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access select |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid in the access cycle |
| diag_ctrl_fail | input | 1 | Controller test failed |
| diag_buf_fail | input | 1 | Buffer test failed |
| diag_cpu_fail | input | 1 | Processor test failed |
| slave_present | input | 1 | A second drive is attached |
| slave_fail | input | 1 | The second drive failed its test |
| bsy | output | 1 | Busy flag |
| drq | output | 1 | Data request flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The interrupt-raising completion of a command and the host's interrupt-clearing status read can land on the same clock edge. The bench provokes this by reading status in the single busy cycle of a read-buffer command. That read must return busy (0x80), and afterwards `irq` must still be high. A second case also tests where the end of a transfer meets the next command: the last data word is followed at once by a new command write, and that command must be accepted in the very next cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PREP_RD = 3'd1,
        S_FILL_ID = 3'd2,
        S_DIAG    = 3'd3,
        S_XFER_RD = 3'd4,
        S_XFER_WR = 3'd5
    } sb_state_e;

    localparam logic [7:0] OP_RD_BUF = 8'hE4;
    localparam logic [7:0] OP_WR_BUF = 8'hE8;
    localparam logic [7:0] OP_IDENT  = 8'hEC;
    localparam logic [7:0] OP_DIAG   = 8'h90;

    localparam logic [7:0] CODE_ABORT = 8'h04;

    localparam logic [2:0] REG_DATA = 3'd0;
    localparam logic [2:0] REG_ERR  = 3'd1;
    localparam logic [2:0] REG_CMD  = 3'd7;

endpackage

// File: rtl/sb_id_rom.sv
module sb_id_rom #(
    parameter int AW    = 8,
    parameter int CYLS  = 977,
    parameter int HEADS = 10,
    parameter int SPT   = 17
) (
    input  logic [AW-1:0] idx,
    output logic [15:0]   word
);
    always_comb begin
        word = 16'h0000;
        case (int'(idx))
            1:       word = 16'(CYLS);
            3:       word = 16'(HEADS);
            6:       word = 16'(SPT);
            default: word = 16'h0000;
        endcase
    end
endmodule

// File: rtl/sb_buffer.sv
module sb_buffer #(
    parameter int WORDS = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [15:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [15:0]   rdata
);
    logic [15:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sb_diag_code.sv
module sb_diag_code (
    input  logic       ctrl_fail,
    input  logic       buf_fail,
    input  logic       cpu_fail,
    input  logic       slave_present,
    input  logic       slave_fail,
    output logic [7:0] code
);
    logic [6:0] local_code;

    always_comb begin
        if (ctrl_fail)     local_code = 7'h02;
        else if (buf_fail) local_code = 7'h03;
        else if (cpu_fail) local_code = 7'h05;
        else               local_code = 7'h01;
        code = {slave_present & slave_fail, local_code};
    end
endmodule

// File: rtl/sb_cmd_seq.sv
module sb_cmd_seq #(
    parameter int WORDS       = 256,
    parameter int DIAG_CYCLES = 16,
    parameter int CYLS        = 977,
    parameter int HEADS       = 10,
    parameter int SPT         = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        diag_ctrl_fail,
    input  logic        diag_buf_fail,
    input  logic        diag_cpu_fail,
    input  logic        slave_present,
    input  logic        slave_fail,
    output logic        bsy,
    output logic        drq,
    output logic        irq
);
    import sb_pkg::*;

    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int CW = (DIAG_CYCLES > 1) ? $clog2(DIAG_CYCLES) : 1;
    localparam logic [AW-1:0] PTR_LAST  = AW'(WORDS - 1);
    localparam logic [CW-1:0] DIAG_LAST = CW'(DIAG_CYCLES - 1);

    typedef struct packed {
        sb_state_e     st;
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          irq;
        logic          err;
        logic [7:0]    code;
    } seq_t;

    seq_t q, d;

    logic [15:0]   rom_word;
    logic [15:0]   buf_rdata;
    logic [7:0]    diag_code;
    logic          buf_we;
    logic [15:0]   buf_wdata;
    logic [7:0]    err_code_q;

    logic acc_data_rd, acc_data_wr, acc_cmd_wr, acc_stat_rd;

    sb_id_rom #(.AW(AW), .CYLS(CYLS), .HEADS(HEADS), .SPT(SPT)) u_rom (
        .idx  (q.ptr),
        .word (rom_word)
    );

    sb_buffer #(.WORDS(WORDS), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (q.ptr),
        .wdata (buf_wdata),
        .raddr (q.ptr),
        .rdata (buf_rdata)
    );

    sb_diag_code u_diag (
        .ctrl_fail     (diag_ctrl_fail),
        .buf_fail      (diag_buf_fail),
        .cpu_fail      (diag_cpu_fail),
        .slave_present (slave_present),
        .slave_fail    (slave_fail),
        .code          (diag_code)
    );

    // access decode
    always_comb begin
        acc_data_rd = host_cs && host_rd && (host_addr == REG_DATA);
        acc_data_wr = host_cs && host_wr && (host_addr == REG_DATA);
        acc_cmd_wr  = host_cs && host_wr && (host_addr == REG_CMD);
        acc_stat_rd = host_cs && host_rd && (host_addr == REG_CMD);
    end

    // next-state logic
    always_comb begin
        d         = q;
        buf_we    = 1'b0;
        buf_wdata = host_wdata;

        // a clearing read loses to any set below in the same cycle
        if (acc_stat_rd) d.irq = 1'b0;

        unique case (q.st)
            S_IDLE: begin
                if (acc_cmd_wr) begin
                    d.ptr = '0;
                    d.cnt = '0;
                    case (host_wdata[7:0])
                        OP_RD_BUF: begin
                            d.st   = S_PREP_RD;
                            d.err  = 1'b0;
                            d.code = 8'h00;
                        end
                        OP_WR_BUF: begin
                            d.st   = S_XFER_WR;
                            d.err  = 1'b0;
                            d.code = 8'h00;
                        end
                        OP_IDENT: begin
                            d.st   = S_FILL_ID;
                            d.err  = 1'b0;
                            d.code = 8'h00;
                        end
                        OP_DIAG: begin
                            d.st   = S_DIAG;
                            d.err  = 1'b0;
                            d.code = 8'h00;
                        end
                        default: begin
                            d.code = CODE_ABORT;
                            d.err  = 1'b1;
                            d.irq  = 1'b1;
                        end
                    endcase
                end
            end
            S_PREP_RD: begin
                d.st  = S_XFER_RD;
                d.irq = 1'b1;
            end
            S_FILL_ID: begin
                buf_we    = 1'b1;
                buf_wdata = rom_word;
                if (q.ptr == PTR_LAST) begin
                    d.st  = S_XFER_RD;
                    d.ptr = '0;
                    d.irq = 1'b1;
                end else begin
                    d.ptr = q.ptr + 1'b1;
                end
            end
            S_DIAG: begin
                if (q.cnt == DIAG_LAST) begin
                    d.st   = S_IDLE;
                    d.code = diag_code;
                    d.irq  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_XFER_RD: begin
                if (acc_data_rd) begin
                    if (q.ptr == PTR_LAST) begin
                        d.st  = S_IDLE;
                        d.ptr = '0;
                    end else begin
                        d.ptr = q.ptr + 1'b1;
                    end
                end
            end
            S_XFER_WR: begin
                if (acc_data_wr) begin
                    buf_we = 1'b1;
                    if (q.ptr == PTR_LAST) begin
                        d.st  = S_IDLE;
                        d.ptr = '0;
                    end else begin
                        d.ptr = q.ptr + 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.ptr  <= '0;
            q.cnt  <= '0;
            q.irq  <= 1'b0;
            q.err  <= 1'b0;
            q.code <= 8'h00;
        end else begin
            q <= d;
        end
    end

    // outputs
    always_comb begin
        bsy        = (q.st == S_PREP_RD) || (q.st == S_FILL_ID) || (q.st == S_DIAG);
        drq        = (q.st == S_XFER_RD) || (q.st == S_XFER_WR);
        irq        = q.irq;
        err_code_q = q.code;
        host_rdata = 16'h0000;
        if (host_cs && host_rd) begin
            case (host_addr)
                REG_DATA: host_rdata = (q.st == S_XFER_RD) ? buf_rdata : 16'h0000;
                REG_ERR:  host_rdata = {8'h00, q.code};
                REG_CMD:  host_rdata = {8'h00, bsy, !bsy, 2'b00, drq, 2'b00, q.err};
                default:  host_rdata = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/sb_cmd_seq_chk.sv
module sb_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_cs,
    input logic        host_rd,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [15:0] host_wdata,
    input logic        slave_present,
    input logic        slave_fail,
    input logic        bsy,
    input logic        drq,
    input logic        irq,
    input logic [7:0]  err_code
);
    logic cmd_idle, stat_rd, data_acc, known;

    always_comb begin
        cmd_idle = host_cs && host_wr && (host_addr == 3'd7) && !bsy && !drq;
        stat_rd  = host_cs && host_rd && !host_wr && (host_addr == 3'd7);
        data_acc = host_cs && (host_addr == 3'd0) && (host_rd || host_wr);
        known    = (host_wdata[7:0] == 8'hE4) || (host_wdata[7:0] == 8'hE8) ||
                   (host_wdata[7:0] == 8'hEC) || (host_wdata[7:0] == 8'h90);
    end

    p_flags_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));

    p_rdbuf_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_idle && host_wdata[7:0] == 8'hE4) |=> (bsy && !drq));

    p_wrbuf_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_idle && host_wdata[7:0] == 8'hE8 && !irq) |=> (drq && !bsy && !irq));

    p_slave_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bsy) && !drq) |-> (err_code[7] == $past(slave_present && slave_fail)));

    p_drq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> $past(data_acc));

    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && stat_rd && !bsy) |=> !irq);

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_idle && !known) |=> (irq && !bsy && !drq && err_code == 8'h04));
endmodule

bind sb_cmd_seq sb_cmd_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_cs       (host_cs),
    .host_rd       (host_rd),
    .host_wr       (host_wr),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .slave_present (slave_present),
    .slave_fail    (slave_fail),
    .bsy           (bsy),
    .drq           (drq),
    .irq           (irq),
    .err_code      (err_code_q)
);

// File: tb/tb_sb_cmd_seq.sv
module tb_sb_cmd_seq;
    localparam int WORDS = 256;
    localparam int DIAG  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        d_ctrl = 1'b0, d_buf = 1'b0, d_cpu = 1'b0, s_pres = 1'b0, s_fail = 1'b0;
    logic        bsy, drq, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sb_cmd_seq #(.WORDS(WORDS), .DIAG_CYCLES(DIAG)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .diag_ctrl_fail(d_ctrl), .diag_buf_fail(d_buf), .diag_cpu_fail(d_cpu),
        .slave_present(s_pres), .slave_fail(s_fail),
        .bsy(bsy), .drq(drq), .irq(irq)
    );

    function automatic logic [15:0] pat(int i);
        return 16'hA500 ^ 16'(i * 7);
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all access tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        host_cs = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(3'd7, v); check(v, 16'h0040, "R1 reset status");
        rd(3'd1, v); check(v, 16'h0000, "R1 reset error");
        check({15'd0, irq}, 16'd0, "R1 reset irq");
    endtask

    task automatic t_write_buffer;
        wr(3'd7, 16'h00E8);
        check({13'd0, bsy, drq, irq}, 16'b010, "R3 write buffer flags");
        wr(3'd7, 16'h0090);
        check({15'd0, bsy}, 16'd0, "R11 command during drq ignored");
        for (int i = 0; i < WORDS; i++) begin
            check({15'd0, drq}, 16'd1, "R7 drq held");
            wr(3'd0, pat(i));
            if (i == 0) check({15'd0, drq}, 16'd1, "R3 first word accepted");
        end
        check({14'd0, drq, irq}, 16'd0, "R7 drq clear no irq");
    endtask

    task automatic t_ignored_accesses;
        logic [15:0] v;
        wr(3'd0, 16'hDEAD);
        rd(3'd0, v); check(v, 16'h0000, "R8 data read while idle");
        for (int a = 2; a < 7; a++) wr(3'(a), 16'h0033);
        wr(3'd1, 16'h00FF);
        rd(3'd1, v); check(v, 16'h0000, "R11 error register write ignored");
        rd(3'd7, v); check(v, 16'h0040, "R11 status after ignored writes");
    endtask

    task automatic t_read_buffer;
        logic [15:0] v;
        int bad;
        wr(3'd7, 16'h00E4);
        check({13'd0, bsy, drq, irq}, 16'b100, "R2 busy phase");
        // status read in the cycle the interrupt is raised
        rd(3'd7, v);
        check(v, 16'h0080, "R9 status during busy");
        check({13'd0, bsy, drq, irq}, 16'b011, "R9 set wins over clear");
        rd(3'd7, v);
        check(v, 16'h0048, "R2 status data request");
        check({15'd0, irq}, 16'd0, "R9 status read clears irq");
        wr(3'd0, 16'h1111);   // wrong direction, not counted
        bad = 0;
        for (int i = 0; i < WORDS; i++) begin
            rd(3'd0, v);
            if (v !== pat(i)) begin
                bad++;
                if (bad < 4) check(v, pat(i), "R2 read word");
            end
        end
        check(16'(bad), 16'd0, "R8 buffer intact after ignored writes");
        check({14'd0, drq, irq}, 16'd0, "R7 read phase ends");
    endtask

    task automatic t_identify;
        logic [15:0] v;
        int n = 0;
        int bad = 0;
        wr(3'd7, 16'h00EC);
        while (bsy && n < 2000) begin n++; @(negedge clk); end
        check(16'(n), 16'(WORDS), "R4 busy length");
        check({14'd0, drq, irq}, 16'b11, "R4 drq and irq");
        for (int i = 0; i < WORDS; i++) begin
            rd(3'd0, v);
            if (i == 1) check(v, 16'd977, "R4 cylinders");
            else if (i == 3) check(v, 16'd10, "R4 heads");
            else if (i == 6) check(v, 16'd17, "R4 sectors");
            else if (v !== 16'h0) bad++;
        end
        check(16'(bad), 16'd0, "R4 zero words");
        // next command right after last transfer
        wr(3'd7, 16'h0042);
        check({13'd0, bsy, drq, irq}, 16'b001, "R10 accepted after transfer");
        rd(3'd1, v); check(v, 16'h0004, "R10 abort code");
        rd(3'd7, v); check(v, 16'h0041, "R10 status err bit");
        check({15'd0, irq}, 16'd0, "R9 clear after abort");
    endtask

    task automatic diag(input logic c, b, p, sp, sf, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        int n = 0;
        d_ctrl = c; d_buf = b; d_cpu = p; s_pres = sp; s_fail = sf;
        wr(3'd7, 16'h0090);
        while (bsy && n < 2000) begin n++; @(negedge clk); end
        check(16'(n), 16'(DIAG), {tag, " busy length R5"});
        check({14'd0, drq, irq}, 16'b01, {tag, " irq no drq R5"});
        rd(3'd1, v); check(v, exp, tag);
        rd(3'd7, v); check(v, 16'h0040, {tag, " status R12"});
    endtask

    task automatic t_diag;
        diag(0, 0, 0, 0, 0, 16'h01, "R5 pass");
        diag(1, 1, 1, 0, 0, 16'h02, "R5 controller");
        diag(0, 1, 1, 0, 0, 16'h03, "R5 buffer");
        diag(0, 0, 1, 0, 0, 16'h05, "R5 processor");
        diag(0, 1, 0, 1, 1, 16'h83, "R6 slave failed");
        diag(0, 0, 0, 0, 1, 16'h01, "R6 slave absent");
        diag(0, 0, 0, 1, 0, 16'h01, "R6 slave passed");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_buffer;
        t_ignored_accesses;
        t_read_buffer;
        t_identify;
        t_diag;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule